// File: doc/BRIEF.md
# Self-Restarting Periodic Interrupt Timer

This block divides a slow time-base tick into a repeating interrupt. A 16-bit down-counter steps once for every cycle in which the one-cycle time-base tick (nominally 100 kHz, produced outside the block) is high. When the count is spent, it reloads itself from a programmable period register and starts again, without any help from software.

Each expiry sets a sticky status flag. While the flag is set, the block holds a level-15 interrupt request toward the interrupt decoder. Software acknowledges the interrupt by writing any value to a dedicated clear address. Counting carries on while the flag is pending, so the period does not drift with interrupt latency.

A small register bus gives access to the block. On this bus the period register can be written and read back, and the status flag can be read.

Top module: `ptmr_top`

## Requirements
- R1: After reset, `irq_o` is 0, the status word reads 0 and the period register reads the parameter `RELOAD_RST` (default 0).
- R2: The count changes only in cycles where `tick_i` is 1; any number of idle cycles between ticks leaves the time to the next expiry unchanged.
- R3: With a period value N (1..65535) held, expiries occur every N ticks indefinitely, with no software action between them.
- R4: A period value of 0 gives an interval of 65536 ticks.
- R5: On the tick that expires the count, the flag at bit 6 of the status word is set and `irq_o` goes to 1 in the following cycle.
- R6: The flag and `irq_o` stay at 1 until a clear write, and ticks keep counting while the flag is set.
- R7: A write of any data to address 0x00042010 clears the flag and `irq_o` in the following cycle.
- R8: If an expiry and a clear write fall in the same cycle, the flag stays set.
- R9: A write to the period register (address 0x00042000, low 16 data bits) discards the running count. The first tick after the write loads the new value N. The next expiry then comes on the N-th tick after that loading tick, and the loading tick itself never expires.
- R10: Reads are combinational from `bus_addr`. Address 0x00042008 returns the flag at bit 6 with every other bit 0. Address 0x00042000 returns the period value in bits 15:0 with zeros above. Any other address reads 0. Writes to the status address have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle time-base enable |
| bus_addr | input | 32 | Register bus address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Level-15 interrupt request, equal to the sticky flag |

## Verification
The period is swept over several small values. Each value is run once with back-to-back ticks and once with idle cycles between ticks, so a counter that advances on the clock is told apart from one that advances on the tick, and off-by-one reload errors show at the exact tick. A long run at period 0 separates a 65536-tick interval from a zero or 65535-tick one. Further patterns cover these cases:
- a mid-count period rewrite, which must restart the count;
- a late clear, whose timing shows that counting continued while the flag was pending;
- a clear that coincides with an expiry, which separates set priority from clear priority.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  // Bit of the status word that carries the periodic flag.
  localparam int unsigned FLAG_BIT = 6;

  // Decoded register access for one bus cycle.
  typedef struct packed {
    logic hit_period;
    logic hit_status;
    logic hit_clear;
  } ptmr_dec_t;

endpackage

// File: rtl/ptmr_rst_sync.sv
module ptmr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import ptmr_pkg::*;
#(
  parameter int unsigned      ADDR_W      = 32,
  parameter int unsigned      DATA_W      = 32,
  parameter int unsigned      CNT_W       = 16,
  parameter logic [ADDR_W-1:0] PERIOD_ADDR = 32'h0004_2000,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 32'h0004_2008,
  parameter logic [ADDR_W-1:0] CLEAR_ADDR  = 32'h0004_2010,
  parameter logic [CNT_W-1:0]  RELOAD_RST  = '0
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              flag_i,
  output logic [CNT_W-1:0]  period_o,
  output logic              period_wr_o,
  output logic              clear_wr_o,
  output logic [DATA_W-1:0] bus_rdata
);

  ptmr_dec_t        dec;
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] period_d;
  logic             period_en;

  // Address decode
  always_comb begin
    dec.hit_period = (bus_addr == PERIOD_ADDR);
    dec.hit_status = (bus_addr == STATUS_ADDR);
    dec.hit_clear  = (bus_addr == CLEAR_ADDR);
  end

  // Period register: next state and enable
  always_comb begin
    period_en = bus_wr && dec.hit_period;
    period_d  = bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      period_q <= RELOAD_RST;
    end else if (period_en) begin
      period_q <= period_d;
    end
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (dec.hit_status) begin
      bus_rdata[FLAG_BIT] = flag_i;
    end else if (dec.hit_period) begin
      bus_rdata[CNT_W-1:0] = period_q;
    end
  end

  assign period_o    = period_q;
  assign period_wr_o = period_en;
  assign clear_wr_o  = bus_wr && dec.hit_clear;

  // R9: a period write is visible on the next cycle
  a_r9_period_capture: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_wr && bus_addr == PERIOD_ADDR) |=> (period_o == $past(bus_wdata[CNT_W-1:0])));

  // R10: the period register holds when it is not addressed by a write
  a_r10_period_hold: assert property (@(posedge clk) disable iff (!srst_n)
    !(bus_wr && bus_addr == PERIOD_ADDR) |=> $stable(period_o));

  // R10: status reads expose nothing outside the flag bit
  a_r10_status_bits: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_addr == STATUS_ADDR) |-> ($countones(bus_rdata) <= 1));

endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
  parameter int unsigned      CNT_W      = 16,
  parameter logic [CNT_W-1:0] RELOAD_RST = '0
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             period_wr_i,
  output logic             expire_o
);

  localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] CNT_RST = RELOAD_RST - ONE;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             pend_q;
  logic             pend_d;
  logic [CNT_W-1:0] load_val;
  logic             at_zero;

  // Remaining ticks minus one; a period of 0 wraps to all ones (2^CNT_W).
  assign load_val = period_i - ONE;
  assign at_zero  = (cnt_q == '0);

  // Next state
  always_comb begin
    cnt_d    = cnt_q;
    expire_o = 1'b0;
    if (tick_i) begin
      if (pend_q) begin
        cnt_d = load_val;
      end else if (at_zero) begin
        cnt_d    = load_val;
        expire_o = 1'b1;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_comb begin
    pend_d = period_wr_i | (pend_q & ~tick_i);
  end

  // Registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q  <= CNT_RST;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  // R2: without a tick the count does not move
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!srst_n)
    !tick_i |=> $stable(cnt_q));

  // R2: an ordinary tick removes exactly one count
  a_r2_step: assert property (@(posedge clk) disable iff (!srst_n)
    (tick_i && !pend_q && !at_zero) |=> (cnt_q == $past(cnt_q) - ONE));

  // R3: expiry restarts the count from the period value
  a_r3_reload: assert property (@(posedge clk) disable iff (!srst_n)
    (tick_i && !pend_q && at_zero) |=> (cnt_q == $past(period_i) - ONE));

  // R9: the loading tick never expires
  a_r9_load_silent: assert property (@(posedge clk) disable iff (!srst_n)
    (tick_i && pend_q) |-> !expire_o);

  // R9: a period write arms the restart
  a_r9_arm: assert property (@(posedge clk) disable iff (!srst_n)
    period_wr_i |=> pend_q);

endmodule

// File: rtl/ptmr_flag.sv
module ptmr_flag (
  input  logic clk,
  input  logic srst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;
  logic flag_d;

  // Set has priority over clear.
  always_comb begin
    flag_d = flag_q;
    if (set_i) begin
      flag_d = 1'b1;
    end else if (clr_i) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  // R5: an expiry sets the flag
  a_r5_set: assert property (@(posedge clk) disable iff (!srst_n)
    set_i |=> flag_o);

  // R6: the flag is sticky without a clear
  a_r6_sticky: assert property (@(posedge clk) disable iff (!srst_n)
    (flag_o && !clr_i) |=> flag_o);

  // R7: a clear without a coincident expiry drops the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (!srst_n)
    (clr_i && !set_i) |=> !flag_o);

  // R8: a coincident set and clear leaves the flag set
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!srst_n)
    (clr_i && set_i) |=> flag_o);

endmodule

// File: rtl/ptmr_top.sv
module ptmr_top #(
  parameter int unsigned       ADDR_W      = 32,
  parameter int unsigned       DATA_W      = 32,
  parameter int unsigned       CNT_W       = 16,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] PERIOD_ADDR = 32'h0004_2000,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 32'h0004_2008,
  parameter logic [ADDR_W-1:0] CLEAR_ADDR  = 32'h0004_2010,
  parameter logic [CNT_W-1:0]  RELOAD_RST  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);

  logic             srst_n;
  logic [CNT_W-1:0] period;
  logic             period_wr;
  logic             clear_wr;
  logic             expire;
  logic             flag;

  ptmr_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (srst_n)
  );

  ptmr_regs #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .CNT_W       (CNT_W),
    .PERIOD_ADDR (PERIOD_ADDR),
    .STATUS_ADDR (STATUS_ADDR),
    .CLEAR_ADDR  (CLEAR_ADDR),
    .RELOAD_RST  (RELOAD_RST)
  ) u_regs (
    .clk         (clk),
    .srst_n      (srst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .flag_i      (flag),
    .period_o    (period),
    .period_wr_o (period_wr),
    .clear_wr_o  (clear_wr),
    .bus_rdata   (bus_rdata)
  );

  ptmr_counter #(
    .CNT_W      (CNT_W),
    .RELOAD_RST (RELOAD_RST)
  ) u_cnt (
    .clk         (clk),
    .srst_n      (srst_n),
    .tick_i      (tick_i),
    .period_i    (period),
    .period_wr_i (period_wr),
    .expire_o    (expire)
  );

  ptmr_flag u_flag (
    .clk    (clk),
    .srst_n (srst_n),
    .set_i  (expire),
    .clr_i  (clear_wr),
    .flag_o (flag)
  );

  assign irq_o = flag;

  // R5: the request rises only one cycle after an expiry
  a_r5_irq_rise: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(irq_o) |-> $past(expire));

  // R1: the request is low while the internal reset is held
  a_r1_reset_quiet: assert property (@(posedge clk)
    !srst_n |-> !irq_o);

endmodule

// File: tb/sim_ptmr_top.sv
module sim_ptmr_top;

  localparam int          CLK_PERIOD  = 10;
  localparam int          WATCHDOG    = 150000;
  localparam logic [31:0] A_PERIOD    = 32'h0004_2000;
  localparam logic [31:0] A_STATUS    = 32'h0004_2008;
  localparam logic [31:0] A_CLEAR     = 32'h0004_2010;
  localparam logic [31:0] FLAG_WORD   = 32'h0000_0040;

  logic        clk;
  logic        rst_n;
  logic        tick;
  logic [31:0] addr;
  logic        wr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int checks;
  int failures;
  int cycles;

  ptmr_top u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .bus_addr  (addr),
    .bus_wr    (wr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .irq_o     (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    addr  = a;
    wdata = d;
    wr    = 1'b1;
    @(negedge clk);
    wr    = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [31:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Watchdog
  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
        finish_run();
      end
    end
  end

  initial begin
    checks   = 0;
    failures = 0;
    rst_n    = 1'b0;
    tick     = 1'b0;
    addr     = '0;
    wr       = 1'b0;
    wdata    = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    read_chk("R1 status", A_STATUS, 32'd0);
    read_chk("R1 period", A_PERIOD, 32'd0);

    // R3/R9/R2: sweep of small periods, dense then sparse ticks
    foreach (sweep_vals[i]) begin
      int n;
      n = sweep_vals[i];
      bus_write(A_PERIOD, n);
      read_chk("R10 period readback", A_PERIOD, n);
      bus_write(A_CLEAR, 32'd0);
      ticks(1);
      chk("R9 loading tick silent", {31'd0, irq}, 32'd0);
      ticks(n - 1);
      chk("R3 no early expiry", {31'd0, irq}, 32'd0);
      ticks(1);
      chk("R5 expiry at N-th tick", {31'd0, irq}, 32'd1);
      read_chk("R5 status flag", A_STATUS, FLAG_WORD);
      bus_write(A_CLEAR, 32'd0);
      chk("R7 clear", {31'd0, irq}, 32'd0);
      for (int k = 1; k <= n; k++) begin
        ticks(1);
        idle(3);
        if (k < n) chk("R2 sparse ticks early", {31'd0, irq}, 32'd0);
        else       chk("R3 sparse ticks period", {31'd0, irq}, 32'd1);
      end
      bus_write(A_CLEAR, 32'd0);
    end

    // R2: a long idle gap does not move the count
    bus_write(A_PERIOD, 32'd4);
    bus_write(A_CLEAR, 32'd0);
    ticks(1);
    ticks(3);
    idle(40);
    chk("R2 idle gap", {31'd0, irq}, 32'd0);
    ticks(1);
    chk("R2 expiry after gap", {31'd0, irq}, 32'd1);

    // R6/R10: sticky flag, ignored status write, counting continues
    idle(20);
    chk("R6 sticky", {31'd0, irq}, 32'd1);
    bus_write(A_STATUS, 32'd0);
    chk("R10 status write ignored", {31'd0, irq}, 32'd1);
    read_chk("R10 status word", A_STATUS, FLAG_WORD);
    read_chk("R10 unmapped read", 32'h0004_2004, 32'd0);
    ticks(3);
    chk("R6 held while counting", {31'd0, irq}, 32'd1);
    bus_write(A_CLEAR, 32'hFFFF_FFFF);
    chk("R7 clear any data", {31'd0, irq}, 32'd0);
    read_chk("R7 status cleared", A_STATUS, 32'd0);
    ticks(1);
    chk("R6 count continued", {31'd0, irq}, 32'd1);

    // R8: expiry and clear in the same cycle
    ticks(3);
    chk("R8 before coincidence", {31'd0, irq}, 32'd1);
    addr  = A_CLEAR;
    wdata = 32'd0;
    wr    = 1'b1;
    tick  = 1'b1;
    @(negedge clk);
    wr    = 1'b0;
    tick  = 1'b0;
    chk("R8 set wins", {31'd0, irq}, 32'd1);
    bus_write(A_CLEAR, 32'd0);
    chk("R7 clear after R8", {31'd0, irq}, 32'd0);

    // R9: mid-count rewrite restarts the count
    bus_write(A_PERIOD, 32'd10);
    ticks(1);
    ticks(4);
    bus_write(A_PERIOD, 32'd3);
    ticks(1);
    chk("R9 rewrite loading tick", {31'd0, irq}, 32'd0);
    ticks(2);
    chk("R9 no early expiry", {31'd0, irq}, 32'd0);
    ticks(1);
    chk("R9 expiry from new value", {31'd0, irq}, 32'd1);
    bus_write(A_CLEAR, 32'd0);

    // R4: period 0 means 65536 ticks
    bus_write(A_PERIOD, 32'd0);
    read_chk("R4 period zero readback", A_PERIOD, 32'd0);
    ticks(1);
    ticks(65535);
    chk("R4 no expiry at 65535", {31'd0, irq}, 32'd0);
    ticks(1);
    chk("R4 expiry at 65536", {31'd0, irq}, 32'd1);

    finish_run();
  end

  int sweep_vals [5] = '{1, 2, 3, 5, 7};

endmodule